// File: doc/BRIEF.md
# Write-Gathering Store Buffer

This block sits between a core's store and load ports and a 64-bit memory bus. It serves a region that is written only, such as a frame buffer or a streaming device. Word stores tagged with the gathering attribute code are collected into a one-line buffer of eight 32-bit words. The line goes out as one 4-beat burst once its last word is written. Every other store goes straight to the bus as a single uncached write.

The buffer is pushed out early in several cases: a barrier, a prefetch nudge, an exception, a load that hits the buffered block, or a gathered store that does not continue the current sequence. A line that is only partly written leaves as a series of 64-bit and 32-bit writes. Loads never read the buffer. They are always served by a single bus read.

Top module: `wgather_buf`

## Requirements
- R1: A store whose attribute code is not 7 is issued as one single write: `bus_len`=0, address aligned to 8 bytes, and its four byte enables placed in `bus_strb[3:0]` when address bit 2 is 0, or in `bus_strb[7:4]` when it is 1.
- R2: A full-word (enables 4'hF) store with attribute 7 whose word index (address bits 4:2) follows the last gathered one in the same 32-byte block (address bits 31:5) is held in the buffer, and no bus request is made for it.
- R3: A full line leaves as one request with `bus_len`=3 at the 32-byte-aligned block address. Each beat has all strobes set. Beats run in ascending doubleword order, with the lower-indexed word in bits 31:0. Address and length stay stable while a beat waits for `bus_ack`.
- R4: A full-word gathered store to a different block while the buffer holds data first drains the held block, and then starts gathering in the new block.
- R5: A pulse on `sync_req`, `nudge_req` or `exc_req` drains a non-empty buffer. With the buffer empty, a pulse causes no bus traffic.
- R6: A load whose block matches the buffered block waits until the buffer has drained before its read is issued.
- R7: A partial drain visits the doublewords in ascending order. A pair with both words valid is one write with strobes 8'hFF. A lone lower word uses 8'h0F and a lone upper word uses 8'hF0. Empty pairs are skipped.
- R8: Every load is one bus read (`bus_we`=0, `bus_len`=0, address aligned to 8 bytes), answered on `ld_ack`. `ld_rdata` is bits 31:0 of the bus data when address bit 2 is 0, and bits 63:32 otherwise.
- R9: `st_ready` is low from the cycle after a line-completing store until the drain has finished.
- R10: A gathered store that is narrower than a word, or that breaks the sequence within the buffered block, causes the buffer to drain first. The store itself then goes out as a single write.
- R11: After reset the buffer is empty, `bus_req` and `ld_ack` are low, and `st_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store accepted this cycle when `st_valid` is high |
| st_addr | input | 32 | Store byte address |
| st_data | input | 32 | Store data word |
| st_be | input | 4 | Store byte enables |
| st_attr | input | 3 | Region attribute code (7 = gather) |
| ld_valid | input | 1 | Load request, held until `ld_ack` |
| ld_addr | input | 32 | Load byte address |
| ld_ack | output | 1 | Load data valid this cycle |
| ld_rdata | output | 32 | Load data word |
| sync_req | input | 1 | Barrier pulse |
| nudge_req | input | 1 | Prefetch-nudge pulse |
| exc_req | input | 1 | Exception pulse |
| bus_req | output | 1 | Bus transaction or beat pending |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Transaction byte address |
| bus_len | output | 2 | Beats minus one |
| bus_wdata | output | 64 | Write data of the current beat |
| bus_strb | output | 8 | Byte strobes of the current beat |
| bus_ack | input | 1 | Current beat accepted or read data returned |
| bus_rdata | input | 64 | Read data, valid with `bus_ack` on reads |

## Verification
The assertions take the bus to be well behaved: `bus_ack` is raised only while `bus_req` is high, and a held request keeps its address and length until acknowledged. They also take trigger inputs to be single-cycle pulses, and a load to be held until `ld_ack`. The stimulus respects all of this. The responder acknowledges only pending beats, after a random delay. Requests are issued one at a time, and every load waits for its acknowledge. Triggers are one-cycle pulses that never coincide with a request. The random mix favours stores that continue the current sequence, so that lines fill, break and drain in many different patterns.

// File: rtl/wg_pkg.sv
// Shared definitions for the write-gathering store buffer.
// Assumes a 64-bit bus made of two 32-bit word lanes, little-endian.
package wg_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SINGLE,
        S_READ,
        S_PICK,
        S_BURST,
        S_DRAIN
    } wg_state_e;

    localparam logic [2:0] ATTR_GATHER = 3'd7;

    // Place 4 byte enables on the lane picked by address bit 2.
    function automatic logic [7:0] lane_strb(input logic hi, input logic [3:0] be);
        return hi ? {be, 4'b0000} : {4'b0000, be};
    endfunction

endpackage

// File: rtl/wg_line.sv
// One-line gathering store: a block tag, per-word valid bits, word data and
// the index the next sequential store must hit.
// Assumes wr_en and clr never arrive in the same cycle.
module wg_line #(
    parameter int WORDS = 8,
    parameter int BLK_W = 27,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [BLK_W-1:0]            wr_blk,
    input  logic [31:0]                 wr_data,
    input  logic                        clr,
    output logic [BLK_W-1:0]            tag,
    output logic [WORDS-1:0]            valid,
    output logic [WORDS-1:0][31:0]      words,
    output logic [IDX_W-1:0]            next_idx
);

    // Tag and sequence pointer follow the latest gathered word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag      <= '0;
            next_idx <= '0;
        end else if (wr_en) begin
            tag      <= wr_blk;
            next_idx <= wr_idx + 1'b1;
        end
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        // Valid bit and data of one word slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid[g] <= 1'b0;
                words[g] <= '0;
            end else if (clr) begin
                valid[g] <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                valid[g] <= 1'b1;
                words[g] <= wr_data;
            end
        end
    end

    // A write into a non-empty line must continue its sequence.
    p_append_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && |valid) |-> (wr_blk == tag && wr_idx == next_idx));

    // Never written and cleared together.
    p_wr_clr_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && clr));

endmodule

// File: rtl/wg_ctrl.sv
// Request arbitration and bus sequencing for the write-gathering buffer.
// Priority in idle: pending flush, then load, then store. Assumes bus_ack
// only while bus_req, and loads held until ld_ack.
module wg_ctrl
    import wg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORDS  = 8,
    localparam int IDX_W  = $clog2(WORDS),
    localparam int PAIRS  = WORDS / 2,
    localparam int PAIR_W = $clog2(PAIRS),
    localparam int OFF_W  = IDX_W + 2,
    localparam int BLK_W  = ADDR_W - OFF_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    st_valid,
    output logic                    st_ready,
    input  logic [ADDR_W-1:0]       st_addr,
    input  logic [31:0]             st_data,
    input  logic [3:0]              st_be,
    input  logic [2:0]              st_attr,
    input  logic                    ld_valid,
    input  logic [ADDR_W-1:0]       ld_addr,
    output logic                    ld_ack,
    output logic [31:0]             ld_rdata,
    input  logic                    flush_trig,
    output logic                    wr_en,
    output logic [IDX_W-1:0]        wr_idx,
    output logic [BLK_W-1:0]        wr_blk,
    output logic [31:0]             wr_data,
    output logic                    clr,
    input  logic [BLK_W-1:0]        tag,
    input  logic [WORDS-1:0]        valid,
    input  logic [WORDS-1:0][31:0]  words,
    input  logic [IDX_W-1:0]        next_idx,
    output logic                    bus_req,
    output logic                    bus_we,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic [PAIR_W-1:0]       bus_len,
    output logic [63:0]             bus_wdata,
    output logic [7:0]              bus_strb,
    input  logic                    bus_ack,
    input  logic [63:0]             bus_rdata
);

    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(WORDS - 1);
    localparam logic [PAIR_W-1:0] LAST_PAIR = PAIR_W'(PAIRS - 1);

    wg_state_e           state_q, state_d;
    logic                flush_q, force_single_q;
    logic [PAIR_W-1:0]   ptr_q;
    logic [ADDR_W-1:0]   sa_q;
    logic [31:0]         sd_q;
    logic [3:0]          sbe_q;

    logic [IDX_W-1:0]    st_idx;
    logic [BLK_W-1:0]    st_blk;
    logic                nonempty, st_gather, st_full, st_same;
    logic                st_append, st_start, st_conflict, ld_hit;
    logic                accept, gather_wr, to_single, pair_done, last_step;
    logic [1:0]          pv;

    assign st_idx      = st_addr[OFF_W-1:2];
    assign st_blk      = st_addr[ADDR_W-1:OFF_W];
    assign nonempty    = |valid;
    assign st_gather   = (st_attr == ATTR_GATHER);
    assign st_full     = (st_be == 4'hF);
    assign st_same     = (st_blk == tag);
    assign st_append   = nonempty && st_full && st_same && (st_idx == next_idx);
    assign st_start    = !nonempty && st_full && !force_single_q;
    assign st_conflict = st_gather && nonempty && !st_append;
    assign ld_hit      = nonempty && (ld_addr[ADDR_W-1:OFF_W] == tag);

    assign st_ready  = (state_q == S_IDLE) && !flush_q && !ld_valid && !st_conflict;
    assign accept    = st_valid && st_ready;
    assign gather_wr = accept && st_gather && (st_append || st_start);
    assign to_single = accept && !gather_wr;

    assign wr_en   = gather_wr;
    assign wr_idx  = st_idx;
    assign wr_blk  = st_blk;
    assign wr_data = st_data;

    assign pv        = {valid[{ptr_q, 1'b1}], valid[{ptr_q, 1'b0}]};
    assign pair_done = (state_q == S_DRAIN) && (pv == 2'b00 || bus_ack);
    assign last_step = (ptr_q == LAST_PAIR);
    assign clr       = ((state_q == S_BURST && bus_ack) || pair_done) && last_step;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (flush_q) begin
                    if (nonempty) state_d = S_PICK;
                end else if (ld_valid) begin
                    state_d = ld_hit ? S_PICK : S_READ;
                end else if (st_valid) begin
                    if (st_conflict)    state_d = S_PICK;
                    else if (gather_wr) state_d = (st_idx == LAST_IDX) ? S_PICK : S_IDLE;
                    else                state_d = S_SINGLE;
                end
            end
            S_SINGLE, S_READ: if (bus_ack) state_d = S_IDLE;
            S_PICK:           state_d = (&valid) ? S_BURST : S_DRAIN;
            S_BURST, S_DRAIN: if (clr) state_d = S_IDLE;
            default:          state_d = S_IDLE;
        endcase
    end

    // State, flush latch, single-write force flag and beat pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q        <= S_IDLE;
            flush_q        <= 1'b0;
            force_single_q <= 1'b0;
            ptr_q          <= '0;
        end else begin
            state_q <= state_d;
            flush_q <= flush_trig || (flush_q && state_q != S_IDLE);
            if (accept)
                force_single_q <= 1'b0;
            else if (state_q == S_IDLE && !flush_q && !ld_valid && st_valid
                     && st_conflict && st_same)
                force_single_q <= 1'b1;
            if (state_q == S_PICK)
                ptr_q <= '0;
            else if ((state_q == S_BURST && bus_ack) || pair_done)
                ptr_q <= ptr_q + 1'b1;
        end
    end

    // Capture of a single write or read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sa_q  <= '0;
            sd_q  <= '0;
            sbe_q <= '0;
        end else if (to_single) begin
            sa_q  <= st_addr;
            sd_q  <= st_data;
            sbe_q <= st_be;
        end else if (state_q == S_IDLE && !flush_q && ld_valid && !ld_hit) begin
            sa_q <= ld_addr;
        end
    end

    // Bus request fields per state.
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b1;
        bus_len   = '0;
        bus_addr  = {sa_q[ADDR_W-1:3], 3'b000};
        bus_wdata = {sd_q, sd_q};
        bus_strb  = lane_strb(sa_q[2], sbe_q);
        unique case (state_q)
            S_SINGLE: bus_req = 1'b1;
            S_READ: begin
                bus_req  = 1'b1;
                bus_we   = 1'b0;
                bus_strb = '0;
            end
            S_BURST: begin
                bus_req   = 1'b1;
                bus_len   = LAST_PAIR;
                bus_addr  = {tag, {OFF_W{1'b0}}};
                bus_wdata = {words[{ptr_q, 1'b1}], words[{ptr_q, 1'b0}]};
                bus_strb  = 8'hFF;
            end
            S_DRAIN: begin
                bus_req   = (pv != 2'b00);
                bus_addr  = {tag, ptr_q, 3'b000};
                bus_wdata = {words[{ptr_q, 1'b1}], words[{ptr_q, 1'b0}]};
                bus_strb  = {{4{pv[1]}}, {4{pv[0]}}};
            end
            default: ;
        endcase
    end

    assign ld_ack   = (state_q == S_READ) && bus_ack;
    assign ld_rdata = sa_q[2] ? bus_rdata[63:32] : bus_rdata[31:0];

    // A waiting beat keeps its request, address and length.
    p_hold_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_len)));

    // Multi-beat requests are full-strobe writes.
    p_burst_strb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_len != '0) |-> (bus_we && bus_strb == 8'hFF));

    // Reads are single beats.
    p_read_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |-> (bus_len == '0));

    // No read completes while its block is still buffered.
    p_ld_nohit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ack |-> !(nonempty && ld_addr[ADDR_W-1:OFF_W] == tag));

    // Stores are never taken while the bus is busy.
    p_stall_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !st_ready);

    // A partial-drain write always carries some strobes.
    p_drain_strb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |-> (bus_strb != 8'h00));

endmodule

// File: rtl/wgather_buf.sv
// Top of the write-gathering store buffer: joins the three trigger pulses,
// the line storage and the controller. Assumes a 64-bit bus and an even
// number of words per line.
module wgather_buf #(
    parameter int ADDR_W     = 32,
    parameter int LINE_WORDS = 8,
    localparam int PAIR_W = $clog2(LINE_WORDS / 2),
    localparam int IDX_W  = $clog2(LINE_WORDS),
    localparam int BLK_W  = ADDR_W - IDX_W - 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                st_valid,
    output logic                st_ready,
    input  logic [ADDR_W-1:0]   st_addr,
    input  logic [31:0]         st_data,
    input  logic [3:0]          st_be,
    input  logic [2:0]          st_attr,
    input  logic                ld_valid,
    input  logic [ADDR_W-1:0]   ld_addr,
    output logic                ld_ack,
    output logic [31:0]         ld_rdata,
    input  logic                sync_req,
    input  logic                nudge_req,
    input  logic                exc_req,
    output logic                bus_req,
    output logic                bus_we,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [PAIR_W-1:0]   bus_len,
    output logic [63:0]         bus_wdata,
    output logic [7:0]          bus_strb,
    input  logic                bus_ack,
    input  logic [63:0]         bus_rdata
);

    logic                          wr_en, clr;
    logic [IDX_W-1:0]              wr_idx, next_idx;
    logic [BLK_W-1:0]              wr_blk, tag;
    logic [31:0]                   wr_data;
    logic [LINE_WORDS-1:0]         valid;
    logic [LINE_WORDS-1:0][31:0]   words;
    logic                          flush_trig;

    assign flush_trig = sync_req || nudge_req || exc_req;

    wg_line #(.WORDS(LINE_WORDS), .BLK_W(BLK_W)) u_line (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_blk(wr_blk), .wr_data(wr_data),
        .clr(clr), .tag(tag), .valid(valid), .words(words), .next_idx(next_idx)
    );

    wg_ctrl #(.ADDR_W(ADDR_W), .WORDS(LINE_WORDS)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_data(st_data), .st_be(st_be), .st_attr(st_attr),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_ack(ld_ack), .ld_rdata(ld_rdata),
        .flush_trig(flush_trig),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_blk(wr_blk), .wr_data(wr_data), .clr(clr),
        .tag(tag), .valid(valid), .words(words), .next_idx(next_idx),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_len(bus_len),
        .bus_wdata(bus_wdata), .bus_strb(bus_strb), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

endmodule

// File: tb/test_wgather_buf.sv
`timescale 1ns/1ps
module test_wgather_buf;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 0, ld_valid = 0, sync_req = 0, nudge_req = 0, exc_req = 0;
    logic        st_ready, ld_ack, bus_req, bus_we, bus_ack = 0;
    logic [31:0] st_addr = 0, st_data = 0, ld_addr = 0, ld_rdata, bus_addr;
    logic [3:0]  st_be = 0;
    logic [2:0]  st_attr = 0;
    logic [1:0]  bus_len;
    logic [63:0] bus_wdata, bus_rdata = 0;
    logic [7:0]  bus_strb;

    always #2.5 clk = ~clk;

    wgather_buf i_wgather_buf (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_data(st_data), .st_be(st_be), .st_attr(st_attr),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_ack(ld_ack), .ld_rdata(ld_rdata),
        .sync_req(sync_req), .nudge_req(nudge_req), .exc_req(exc_req),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_len(bus_len),
        .bus_wdata(bus_wdata), .bus_strb(bus_strb), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Expected bus beats, in order.
    localparam int QN = 16384;
    logic        e_we  [QN];
    logic [31:0] e_addr[QN];
    logic [1:0]  e_len [QN];
    logic [63:0] e_data[QN];
    logic [7:0]  e_strb[QN];
    string       e_tag [QN];
    int          q_head = 0, q_tail = 0;

    function automatic void push(input logic we, input logic [31:0] a, input logic [1:0] len,
                                 input logic [63:0] d, input logic [7:0] s, input string tag);
        e_we[q_tail] = we; e_addr[q_tail] = a; e_len[q_tail] = len;
        e_data[q_tail] = d; e_strb[q_tail] = s; e_tag[q_tail] = tag;
        q_tail++;
    endfunction

    function automatic logic [63:0] mask64(input logic [7:0] s);
        logic [63:0] m;
        for (int i = 0; i < 8; i++) m[8*i +: 8] = {8{s[i]}};
        return m;
    endfunction

    function automatic logic [63:0] rd_fn(input logic [31:0] a);
        return {a ^ 32'h5A5A_0000, ~a};
    endfunction

    // Bench model of the buffer.
    logic [31:0] m_data[8];
    logic [7:0]  m_val = 0;
    logic [26:0] m_tag = 0;
    int          m_next = 0;
    bit          m_force = 0;

    function automatic void model_drain(input string tag);
        if (m_val == 0) return;
        if (&m_val) begin
            for (int b = 0; b < 4; b++)
                push(1, {m_tag, 5'b0}, 2'd3, {m_data[2*b+1], m_data[2*b]}, 8'hFF, "R3");
        end else begin
            for (int p = 0; p < 4; p++) begin
                logic [7:0] s;
                s = {{4{m_val[2*p+1]}}, {4{m_val[2*p]}}};
                if (s != 0)
                    push(1, {m_tag, p[1:0], 3'b0}, 2'd0, {m_data[2*p+1], m_data[2*p]}, s, tag);
            end
        end
        m_val = 0;
    endfunction

    function automatic void model_write(input logic [31:0] a, input logic [31:0] d);
        m_val[a[4:2]] = 1'b1; m_data[a[4:2]] = d;
        m_tag = a[31:5]; m_next = (int'(a[4:2]) + 1) % 8;
        m_force = 0;
        if (a[4:2] == 3'd7) model_drain("R7");
    endfunction

    function automatic void push_single(input logic [31:0] a, input logic [31:0] d,
                                        input logic [3:0] be, input string tag);
        push(1, {a[31:3], 3'b0}, 2'd0, {d, d}, a[2] ? {be, 4'h0} : {4'h0, be}, tag);
    endfunction

    function automatic void model_store(input logic [31:0] a, input logic [31:0] d,
                                        input logic [3:0] be, input logic [2:0] attr);
        bit full, same;
        if (attr != 3'd7) begin push_single(a, d, be, "R1"); return; end
        full = (be == 4'hF);
        same = (a[31:5] == m_tag);
        if (m_val != 0) begin
            if (full && same && int'(a[4:2]) == m_next) begin model_write(a, d); return; end
            model_drain((same || !full) ? "R10" : "R4");
            if (same) m_force = 1;
        end
        if (full && !m_force) model_write(a, d);
        else begin push_single(a, d, be, "R10"); m_force = 0; end
    endfunction

    function automatic void model_load(input logic [31:0] a);
        if (m_val != 0 && a[31:5] == m_tag) model_drain("R6");
        push(0, {a[31:3], 3'b0}, 2'd0, 64'd0, 8'h00, "R8");
    endfunction

    // Bus responder: random acknowledge delay, checks each accepted beat.
    initial begin
        forever begin
            @(negedge clk);
            bus_ack = 1'b0;
            if (rst_n && bus_req && ($urandom % 3 != 0)) begin
                bus_ack   = 1'b1;
                bus_rdata = rd_fn(bus_addr);
                if (q_head == q_tail) begin
                    chk(0, "R2", "unexpected beat addr", {32'd0, bus_addr}, 64'd0);
                end else begin
                    chk(bus_addr == e_addr[q_head], e_tag[q_head], "beat addr",
                        {32'd0, bus_addr}, {32'd0, e_addr[q_head]});
                    chk({bus_we, bus_len, bus_strb} == {e_we[q_head], e_len[q_head], e_strb[q_head]},
                        e_tag[q_head], "beat we/len/strb",
                        {53'd0, bus_we, bus_len, bus_strb},
                        {53'd0, e_we[q_head], e_len[q_head], e_strb[q_head]});
                    if (bus_we)
                        chk((bus_wdata & mask64(bus_strb)) == (e_data[q_head] & mask64(bus_strb)),
                            e_tag[q_head], "beat data",
                            bus_wdata & mask64(bus_strb), e_data[q_head] & mask64(bus_strb));
                    q_head++;
                end
            end
        end
    end

    task automatic do_store(input logic [31:0] a, input logic [31:0] d,
                            input logic [3:0] be, input logic [2:0] attr);
        model_store(a, d, be, attr);
        @(negedge clk);
        st_valid = 1; st_addr = a; st_data = d; st_be = be; st_attr = attr;
        forever begin
            #1;
            if (st_ready) break;
            @(negedge clk);
        end
        @(negedge clk);
        st_valid = 0;
    endtask

    task automatic do_load(input logic [31:0] a);
        logic [63:0] r;
        model_load(a);
        r = rd_fn({a[31:3], 3'b0});
        @(negedge clk);
        ld_valid = 1; ld_addr = a;
        forever begin
            #1;
            if (ld_ack) break;
            @(negedge clk);
        end
        chk(ld_rdata == (a[2] ? r[63:32] : r[31:0]), "R8", "load data",
            {32'd0, ld_rdata}, {32'd0, a[2] ? r[63:32] : r[31:0]});
        @(negedge clk);
        ld_valid = 0;
    endtask

    task automatic pulse(input int kind);
        model_drain("R5");
        @(negedge clk);
        if (kind == 0) sync_req = 1; else if (kind == 1) nudge_req = 1; else exc_req = 1;
        @(negedge clk);
        sync_req = 0; nudge_req = 0; exc_req = 0;
    endtask

    // Wait until every expected beat is seen, then require a quiet bus.
    task automatic settle(input string tag);
        bit quiet = 1;
        for (int i = 0; i < 3000 && q_head != q_tail; i++) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            #1;
            if (bus_req) quiet = 0;
        end
        chk(q_head == q_tail && quiet, tag, "outstanding beats / quiet bus",
            64'(q_tail - q_head), 64'd0);
    endtask

    function automatic logic [31:0] wa(input int blk, input int idx);
        return 32'h1000_0000 + 32'(blk * 32 + idx * 4);
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        #1;
        chk(!bus_req && !ld_ack, "R11", "bus_req/ld_ack after reset", {62'd0, bus_req, ld_ack}, 64'd0);
        chk(st_ready, "R11", "st_ready after reset", {63'd0, st_ready}, 64'd1);

        // R2 then R3 and R9: gather a full line.
        for (int i = 0; i < 6; i++) do_store(wa(0, i), 32'hA000_0000 + i, 4'hF, 3'd7);
        begin
            bit quiet = 1;
            for (int i = 0; i < 20; i++) begin @(negedge clk); #1; if (bus_req) quiet = 0; end
            chk(quiet, "R2", "bus idle while gathering", {63'd0, !quiet}, 64'd0);
        end
        do_store(wa(0, 6), 32'hA000_0006, 4'hF, 3'd7);
        model_store(wa(0, 7), 32'hA000_0007, 4'hF, 3'd7);
        @(negedge clk);
        st_valid = 1; st_addr = wa(0, 7); st_data = 32'hA000_0007; st_be = 4'hF; st_attr = 3'd7;
        #1;
        chk(st_ready, "R2", "last word accepted", {63'd0, st_ready}, 64'd1);
        @(negedge clk);
        st_valid = 0;
        #1;
        chk(!st_ready, "R9", "st_ready during drain", {63'd0, st_ready}, 64'd0);
        settle("R3");

        // R1: uncached stores.
        do_store(wa(5, 1), 32'h1234_5678, 4'h3, 3'd2);
        do_store(wa(5, 2), 32'hCAFE_F00D, 4'hF, 3'd0);
        settle("R1");

        // R5: each trigger drains; a trigger with nothing buffered does nothing.
        for (int i = 0; i < 3; i++) do_store(wa(1, i), 32'hB000_0000 + i, 4'hF, 3'd7);
        pulse(0); settle("R5");
        do_store(wa(1, 3), 32'hB100_0003, 4'hF, 3'd7); pulse(1); settle("R5");
        do_store(wa(1, 5), 32'hB200_0005, 4'hF, 3'd7); pulse(2); settle("R5");
        pulse(0); settle("R5");

        // R4: switch block.
        for (int i = 0; i < 3; i++) do_store(wa(2, i), 32'hC000_0000 + i, 4'hF, 3'd7);
        do_store(wa(3, 0), 32'hD000_0000, 4'hF, 3'd7);
        settle("R4");

        // R6: load hitting the buffer; R8: load with empty buffer.
        do_store(wa(3, 1), 32'hD000_0001, 4'hF, 3'd7);
        do_load(wa(3, 1));
        settle("R6");
        do_load(wa(6, 0));
        settle("R8");

        // R10: out-of-sequence and narrow gathered stores.
        do_store(wa(4, 0), 32'hE000_0000, 4'hF, 3'd7);
        do_store(wa(4, 1), 32'hE000_0001, 4'hF, 3'd7);
        do_store(wa(4, 3), 32'hE000_0003, 4'hF, 3'd7);
        do_store(wa(4, 4), 32'hE000_0004, 4'h1, 3'd7);
        settle("R10");

        // R7: line started mid-way, closed by its last word.
        for (int i = 5; i < 8; i++) do_store(wa(7, i), 32'hF000_0000 + i, 4'hF, 3'd7);
        settle("R7");

        // Random mix.
        for (int k = 0; k < 600; k++) begin
            int r = $urandom % 100;
            int b = $urandom % 3;
            int x = $urandom % 8;
            logic [31:0] d = $urandom;
            if (r < 50) begin
                if (m_val != 0) do_store({m_tag, 3'(m_next), 2'b0}, d, 4'hF, 3'd7);
                else            do_store(wa(b, x), d, 4'hF, 3'd7);
            end else if (r < 60) do_store(wa(b, x), d, 4'hF, 3'd7);
            else if (r < 68) begin
                logic [3:0] bes[6] = '{4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'hC};
                do_store(wa(b, x), d, bes[$urandom % 6], 3'd7);
            end else if (r < 78) do_store(wa(b, x), d, 4'(($urandom % 15) + 1), 3'd2);
            else if (r < 90) do_load(wa(b, x));
            else pulse($urandom % 3);
        end
        pulse(0);
        settle("R5");
        done = 1;
    end

    // Watchdog and summary.
    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) chk(0, "R11", "watchdog expired", 64'd0, 64'd1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule